// File: doc/BRIEF.md
# Dual-Edge PDM Capture Demultiplexer

This block drives the bit clock for up to four pulse-density-modulated microphone data lines and turns what it samples into one frame of per-channel values per bit-clock period. A clock divider elsewhere supplies a one-cycle tick for every half period. Each tick toggles the generated PDM clock. The cycle in which that clock goes high is the rising-edge event, and the cycle in which it goes low is the falling-edge event. The data lines are sampled in the system clock domain during those event cycles.

In stereo mode every line carries two microphones. The sample taken at the rising edge becomes the left channel and the sample taken at the falling edge becomes the right channel, so four lines give eight channels. In mono mode only two single-edge microphones are used, and both are sampled at the rising edge. Line index 1 gives the left channel and line index 0 gives the right channel. Each channel bit is presented as a 2-bit signed value of +1 or -1 for the integrators that follow. The falling-edge half of a period is held until the next rising edge, so that all channels of one period leave the block together.

The output is a valid/ready stream that cannot stall, because the microphones run in real time. A frame stays on the port, unchanged, until it is accepted. A new frame that arrives before the old one was taken replaces it. The ready input therefore never slows capture.

Top module: `pdm_capture_demux`

## Requirements
- R1: Out of reset, `pdm_clk_o` inverts in the cycle after each cycle with `pdm_tick_i` high and holds its value after every cycle with the tick low. A tick while the clock is low is a rising-edge event. A tick while the clock is high is a falling-edge event.
- R2: In stereo mode (`mode_mono_i`=0), the value of line k sampled in a rising-edge event cycle appears as channel 2k of the frame for that period.
- R3: In stereo mode, the value of line k sampled in the falling-edge event cycle of the same period appears as channel 2k+1 of the frame.
- R4: A frame is loaded in the cycle after the rising-edge event that ends a period, and it carries the samples of that just-ended period. The first rising-edge event after reset produces no frame.
- R5: In mono mode (`mode_mono_i`=1), channel 0 is line index 1 sampled in the rising-edge event, and channel 1 is line index 0 sampled in the same event.
- R6: In mono mode, channels 2 to 7 carry code 2'b00, and the falling-edge samples have no effect on the frame.
- R7: Channel c occupies `out_pcm_o[2c+1:2c]`. A sampled 1 is coded 2'b01 (+1) and a sampled 0 is coded 2'b11 (-1).
- R8: The mode applied to a frame is the value of `mode_mono_i` in the rising-edge event that opened that period.
- R9: While `rst_n` is low, `pdm_clk_o` and `out_valid_o` are low and ticks have no effect.
- R10: While `out_valid_o` is high and `out_ready_i` is low, `out_valid_o` and `out_pcm_o` hold. When the frame is accepted and no new frame is loaded, `out_valid_o` is low in the next cycle. A newly loaded frame replaces an unaccepted one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pdm_tick_i | input | 1 | Half-period tick from the clock divider |
| mode_mono_i | input | 1 | 0 selects stereo dual-edge capture, 1 selects mono single-edge capture |
| pdm_data_i | input | 4 | PDM data lines, index 0 to 3 |
| pdm_clk_o | output | 1 | Generated PDM clock to the microphones |
| out_valid_o | output | 1 | A frame is present on `out_pcm_o` |
| out_ready_i | input | 1 | The consumer accepts the frame in this cycle |
| out_pcm_o | output | 16 | Eight 2-bit signed channel codes, channel 0 in the low bits |

## Verification
A wrong edge-event decode or a stale hold register shows up at the ports as a wrong or swapped channel code in the very next frame, so it is visible one bit-clock period after the bad sample. A lost period-complete flag shows up as a frame missing after reset, or as a spurious first frame, and that is visible at the second rising-edge event. A broken hand-off to the output register shows up within one cycle, either as a frame that changes while it is not yet accepted or as valid staying high after acceptance. The sweep covers every pair of rising and falling line values in both modes and at three tick spacings, so every channel slot and every mapping is compared.

// File: rtl/pdm_cap_pkg.sv
package pdm_cap_pkg;

  typedef enum logic {
    CAP_STEREO = 1'b0,
    CAP_MONO   = 1'b1
  } cap_mode_e;

  localparam int CODE_W = 2;

  typedef logic signed [CODE_W-1:0] pm1_t;

  localparam pm1_t CODE_POS  = 2'sb01;
  localparam pm1_t CODE_NEG  = 2'sb11;
  localparam pm1_t CODE_NONE = 2'sb00;

  function automatic pm1_t bit_to_pm1(input logic b);
    return b ? CODE_POS : CODE_NEG;
  endfunction

endpackage

// File: rtl/pdm_clk_gen.sv
module pdm_clk_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  output logic pdm_clk_o,
  output logic rise_o,
  output logic fall_o
);

  logic pclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pclk_q <= 1'b0;
    end else if (tick_i) begin
      pclk_q <= ~pclk_q;
    end
  end

  assign rise_o    = tick_i & ~pclk_q;
  assign fall_o    = tick_i &  pclk_q;
  assign pdm_clk_o = pclk_q;

  AST_CLK_TOGGLES_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i |=> (pdm_clk_o != $past(pdm_clk_o))); // R1

  AST_CLK_HOLDS_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(pdm_clk_o)); // R1

endmodule

// File: rtl/pdm_edge_sampler.sv
module pdm_edge_sampler #(
  parameter int LINES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise_i,
  input  logic             fall_i,
  input  logic             mono_i,
  input  logic [LINES-1:0] data_i,
  output logic [LINES-1:0] rise_q_o,
  output logic [LINES-1:0] fall_q_o,
  output logic             mono_q_o,
  output logic             frame_go_o
);

  logic have_q;

  // One hold register per line and edge; the falling half waits for the next rise.
  for (genvar k = 0; k < LINES; k++) begin : g_line
    logic r_q, f_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        r_q <= 1'b0;
        f_q <= 1'b0;
      end else begin
        if (rise_i) r_q <= data_i[k];
        if (fall_i) f_q <= data_i[k];
      end
    end
    assign rise_q_o[k] = r_q;
    assign fall_q_o[k] = f_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mono_q_o <= 1'b0;
      have_q   <= 1'b0;
    end else begin
      if (rise_i) mono_q_o <= mono_i;
      if (fall_i) have_q   <= 1'b1;
    end
  end

  assign frame_go_o = rise_i & have_q;

  AST_EDGES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_i && fall_i)); // R1

  AST_RISE_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rise_i |=> $stable(rise_q_o)); // R2

  AST_FALL_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !fall_i |=> $stable(fall_q_o)); // R3

endmodule

// File: rtl/pdm_frame_map.sv
module pdm_frame_map
  import pdm_cap_pkg::*;
#(
  parameter int LINES = 4,
  localparam int CH   = 2 * LINES,
  localparam int PW   = CH * CODE_W
) (
  input  logic [LINES-1:0] rise_i,
  input  logic [LINES-1:0] fall_i,
  input  logic             mono_i,
  output logic [PW-1:0]    pcm_o
);

  cap_mode_e mode;
  assign mode = cap_mode_e'(mono_i);

  for (genvar k = 0; k < LINES; k++) begin : g_pair
    pm1_t left_c, right_c;
    if (k == 0) begin : g_first
      // Single-edge microphones: line 1 is left, line 0 is right.
      assign left_c  = (mode == CAP_MONO) ? bit_to_pm1(rise_i[1]) : bit_to_pm1(rise_i[0]);
      assign right_c = (mode == CAP_MONO) ? bit_to_pm1(rise_i[0]) : bit_to_pm1(fall_i[0]);
    end else begin : g_rest
      assign left_c  = (mode == CAP_MONO) ? CODE_NONE : bit_to_pm1(rise_i[k]);
      assign right_c = (mode == CAP_MONO) ? CODE_NONE : bit_to_pm1(fall_i[k]);
    end
    assign pcm_o[(2*k)*CODE_W   +: CODE_W] = left_c;
    assign pcm_o[(2*k+1)*CODE_W +: CODE_W] = right_c;
  end

endmodule

// File: rtl/pdm_out_stage.sv
module pdm_out_stage
  import pdm_cap_pkg::*;
#(
  parameter int CH  = 8,
  localparam int PW = CH * CODE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [PW-1:0] pcm_i,
  input  logic          mono_i,
  input  logic          ready_i,
  output logic          valid_o,
  output logic [PW-1:0] pcm_o
);

  logic mono_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      pcm_o   <= '0;
      mono_q  <= 1'b0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      pcm_o   <= pcm_i;
      mono_q  <= mono_i;
    end else if (valid_o && ready_i) begin
      valid_o <= 1'b0;
    end
  end

  AST_HOLD_UNTIL_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ready_i && !load_i) |=> (valid_o && $stable(pcm_o))); // R10

  AST_TAKEN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && ready_i && !load_i) |=> !valid_o); // R10

  AST_MONO_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && mono_q) |-> (pcm_o[PW-1:2*CODE_W] == '0)); // R6

  for (genvar c = 0; c < CH; c++) begin : g_chk
    AST_STEREO_CODE_PM1: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && !mono_q) |-> (pcm_o[c*CODE_W +: CODE_W] == CODE_POS ||
                                pcm_o[c*CODE_W +: CODE_W] == CODE_NEG)); // R7
  end

endmodule

// File: rtl/pdm_capture_demux.sv
module pdm_capture_demux
  import pdm_cap_pkg::*;
#(
  parameter int LINES = 4,
  localparam int CH   = 2 * LINES,
  localparam int PW   = CH * CODE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pdm_tick_i,
  input  logic             mode_mono_i,
  input  logic [LINES-1:0] pdm_data_i,
  output logic             pdm_clk_o,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic [PW-1:0]    out_pcm_o
);

  logic             rise, fall, frame_go, mono_q;
  logic [LINES-1:0] rise_q, fall_q;
  logic [PW-1:0]    frame_pcm;

  pdm_clk_gen i_clk_gen (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (pdm_tick_i),
    .pdm_clk_o (pdm_clk_o),
    .rise_o    (rise),
    .fall_o    (fall)
  );

  pdm_edge_sampler #(.LINES(LINES)) i_sampler (
    .clk        (clk),
    .rst_n      (rst_n),
    .rise_i     (rise),
    .fall_i     (fall),
    .mono_i     (mode_mono_i),
    .data_i     (pdm_data_i),
    .rise_q_o   (rise_q),
    .fall_q_o   (fall_q),
    .mono_q_o   (mono_q),
    .frame_go_o (frame_go)
  );

  pdm_frame_map #(.LINES(LINES)) i_map (
    .rise_i (rise_q),
    .fall_i (fall_q),
    .mono_i (mono_q),
    .pcm_o  (frame_pcm)
  );

  pdm_out_stage #(.CH(CH)) i_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (frame_go),
    .pcm_i   (frame_pcm),
    .mono_i  (mono_q),
    .ready_i (out_ready_i),
    .valid_o (out_valid_o),
    .pcm_o   (out_pcm_o)
  );

  AST_FRAME_AFTER_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid_o) |-> $past(pdm_tick_i && !pdm_clk_o)); // R4

endmodule

// File: tb/test_pdm_capture_demux.sv
module test_pdm_capture_demux;

  localparam int LINES = 4;
  localparam int CH    = 2 * LINES;
  localparam int PW    = 2 * CH;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             tick = 1'b0;
  logic             mode = 1'b0;
  logic [LINES-1:0] data = '0;
  logic             ready = 1'b0;
  logic             pdm_clk;
  logic             out_valid;
  logic [PW-1:0]    out_pcm;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  pdm_capture_demux i_pdm_capture_demux (
    .clk         (clk),
    .rst_n       (rst_n),
    .pdm_tick_i  (tick),
    .mode_mono_i (mode),
    .pdm_data_i  (data),
    .pdm_clk_o   (pdm_clk),
    .out_valid_o (out_valid),
    .out_ready_i (ready),
    .out_pcm_o   (out_pcm)
  );

  // Expected frame from the requirements (R2 R3 R5 R6 R7).
  function automatic logic [PW-1:0] expect_frame(input logic [LINES-1:0] r,
                                                 input logic [LINES-1:0] f,
                                                 input logic m);
    logic [PW-1:0] v = '0;
    if (m) begin
      v[1:0] = r[1] ? 2'b01 : 2'b11;
      v[3:2] = r[0] ? 2'b01 : 2'b11;
    end else begin
      for (int k = 0; k < LINES; k++) begin
        v[4*k   +: 2] = r[k] ? 2'b01 : 2'b11;
        v[4*k+2 +: 2] = f[k] ? 2'b01 : 2'b11;
      end
    end
    return v;
  endfunction

  logic             m_clk, m_have, m_mode, e_valid, e_mono;
  logic [LINES-1:0] m_r, m_f;
  logic [PW-1:0]    e_pcm;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_clk = 0; m_have = 0; m_mode = 0; e_valid = 0; e_mono = 0;
      m_r = '0; m_f = '0; e_pcm = '0;
    end else begin
      logic ld;
      ld = 1'b0;
      if (tick) begin
        if (!m_clk) begin
          if (m_have) begin
            e_pcm = expect_frame(m_r, m_f, m_mode);
            e_mono = m_mode;
            ld = 1'b1;
          end
          m_r = data; m_mode = mode; m_clk = 1'b1;
        end else begin
          m_f = data; m_have = 1'b1; m_clk = 1'b0;
        end
      end
      if (ld) e_valid = 1'b1;
      else if (e_valid && ready) e_valid = 1'b0;
    end
  end

  task automatic check_ports();
    n_checks++;
    if (pdm_clk !== m_clk) begin
      n_fail++;
      $display("FAIL R1 R9 pdm_clk actual %b expected %b", pdm_clk, m_clk);
    end
    n_checks++;
    if (out_valid !== e_valid) begin
      n_fail++;
      $display("FAIL R4 R10 out_valid actual %b expected %b", out_valid, e_valid);
    end
    if (e_valid) begin
      n_checks++;
      if (out_pcm !== e_pcm) begin
        n_fail++;
        if (e_mono)
          $display("FAIL R5 R6 R7 R8 out_pcm actual %h expected %h", out_pcm, e_pcm);
        else
          $display("FAIL R2 R3 R7 R8 out_pcm actual %h expected %h", out_pcm, e_pcm);
      end
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  int cyc = 0;

  function automatic logic ready_for(input int k, input int c);
    if (k == 1) return 1'b1;
    if (k == 2) return (c % 5) != 0;
    return (c % 4) == 0;
  endfunction

  task automatic half(input logic [LINES-1:0] v, input logic m, input int k);
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      check_ports();
      cyc++;
      data  = v;
      mode  = m;
      tick  = (i == k - 1);
      ready = ready_for(k, cyc);
    end
  endtask

  initial begin
    // R9: ticks during reset leave the clock and valid low.
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      tick = ~tick;
      data = 4'hF;
      n_checks++;
      if (pdm_clk !== 1'b0 || out_valid !== 1'b0) begin
        n_fail++;
        $display("FAIL R9 reset clk/valid actual %b%b expected 00", pdm_clk, out_valid);
      end
    end
    @(negedge clk);
    tick = 1'b0;
    rst_n = 1'b1;
    for (int k = 1; k <= 3; k++) begin
      for (int m = 0; m < 2; m++) begin
        for (int r = 0; r < 16; r++) begin
          for (int f = 0; f < 16; f++) begin
            half(4'(r), 1'(m), k);
            half(4'(f), 1'(m), k);
          end
        end
      end
    end
    // Mode change on a period boundary: mode at the opening rise rules (R8).
    half(4'h5, 1'b1, 2); half(4'hA, 1'b0, 2);
    half(4'h6, 1'b0, 2); half(4'h9, 1'b1, 2);
    half(4'h3, 1'b1, 2); half(4'hC, 1'b1, 2);
    for (int i = 0; i < 4; i++) half(4'h0, 1'b0, 1);
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual running expected finished");
    finish_run();
  end

endmodule